// File: doc/BRIEF.md
# Framed Convolutional Encoder with Run-Time Rate Choice

This block turns a framed, bit-serial message into channel symbols using a constraint-length-3 convolutional code. It has two memory bits, so the trellis has four states. The generators are 111 and 101 (octal 7 and 5). A bit is accepted on a cycle where `in_valid` and `in_ready` are both high. An accepted bit that carries `in_sof` starts a new frame: the encoder memory is cleared first and the bit is then encoded. An accepted bit that carries `in_last` ends the message. The encoder then inserts two zero-input steps by itself, so the trellis returns to the all-zero state, and it holds `in_ready` low while it does so.

One encoder serves both output rates, chosen per frame by `rate_sel`. Rate 1/2 sends both generator outputs for every step. Rate 2/3 punctures over pairs of steps: the first step of a pair sends both outputs, and the second sends only the output of the 111 generator. Each symbol leaves on a registered output one cycle after its step. `sym_pair` gives the number of bits the symbol holds, and `sym_eof` marks the last symbol of a frame.

Top module: `tcc_encoder`

## Requirements
- R1: While reset is held, and after it is released with no input, `sym_valid` is 0 and `in_ready` is 1.
- R2: For a step with input b and memory (d1 = previous input, d2 = the one before), the symbol has `sym_bits[1]` = b^d1^d2 and `sym_bits[0]` = b^d2. It appears with `sym_valid` high exactly one cycle after the step. Starting from state 00, input 0 gives 00 and input 1 gives 11.
- R3: An accepted bit with `in_sof` high clears the memory to 00 before that bit is encoded, even in the middle of a frame. It also restarts the puncturing pair count.
- R4: After an accepted bit with `in_last` high, the next two cycles each produce one encoder step with input 0, and `in_ready` is low during both. `in_ready` is high again on the cycle after.
- R5: The second flush symbol carries `sym_eof` = 1, and at that point the encoder memory is 00. No other symbol carries `sym_eof`.
- R6: With `rate_sel` = 0 (rate 1/2), every symbol has `sym_pair` = 1 and carries both generator outputs.
- R7: With `rate_sel` = 1 (rate 2/3), steps are counted from 0 at the start-of-frame bit, flush steps included. Even steps send both outputs with `sym_pair` = 1. Odd steps send the 111-generator output in `sym_bits[1]`, with `sym_bits[0]` = 0 and `sym_pair` = 0.
- R8: `rate_sel` is sampled only with an accepted start-of-frame bit. Changes later in the frame, flush steps included, have no effect.
- R9: A cycle with neither an accepted bit nor a flush step produces no symbol and leaves the memory unchanged, so a frame with idle gaps encodes the same as one sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit is offered this cycle |
| in_bit | input | 1 | Message bit |
| in_sof | input | 1 | Offered bit is the first of a frame |
| in_last | input | 1 | Offered bit is the last message bit of a frame |
| rate_sel | input | 1 | 0 selects rate 1/2, 1 selects rate 2/3 (sampled with the first bit) |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| sym_valid | output | 1 | A symbol is present this cycle |
| sym_bits | output | 2 | Symbol: [1] from generator 111, [0] from generator 101 (0 when punctured) |
| sym_pair | output | 1 | 1 when both symbol bits are meaningful, 0 when only [1] is |
| sym_eof | output | 1 | This symbol is the last of the frame |

## Verification
The in-RTL assertions watch, on every cycle, the properties that hold whatever the data:
- the memory stays frozen on idle cycles;
- a flush run stops after its final step;
- a single-bit symbol appears only in rate 2/3 and has its low bit zero;
- the latched rate moves only on a start-of-frame step;
- the memory is zero whenever an end-of-frame symbol leaves.

The symbol values themselves can only be shown by the bench's scenarios, which compare every symbol against a reference encoder. The scenarios cover:
- full-length frames at both rates;
- idle gaps;
- a rate toggled mid-frame;
- a new frame that cuts off an unfinished one;
- a one-bit frame.

The bench also samples `in_ready` low during each flush.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic {
    RATE_1_2 = 1'b0,
    RATE_2_3 = 1'b1
  } rate_e;

  typedef struct packed {
    logic [1:0] bits;
    logic       pair;
    logic       eof;
  } sym_t;

endpackage

// File: rtl/tcc_shift_core.sv
module tcc_shift_core #(
  parameter int            K  = 3,
  parameter logic [K-1:0]  GA = 3'b111,
  parameter logic [K-1:0]  GB = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clear,
  input  logic         din,
  output logic [1:0]   code,
  output logic [K-2:0] state
);
  localparam int M = K - 1;

  logic [M-1:0] sr_q, sr_d, base;

  always_comb begin
    base    = clear ? '0 : sr_q;
    code[1] = ^({din, base} & GA);
    code[0] = ^({din, base} & GB);
    sr_d    = sr_q;
    if (step) sr_d = {din, base[M-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign state = sr_q;

  // R9: memory frozen when no step occurs
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> sr_q == $past(sr_q));

endmodule

// File: rtl/tcc_flush_ctrl.sv
module tcc_flush_ctrl #(
  parameter int NFLUSH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic flushing,
  output logic final_step
);
  localparam int CW = $clog2(NFLUSH + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    flushing   = (cnt_q != '0);
    final_step = (cnt_q == CW'(1));
    cnt_d      = cnt_q;
    if (start)         cnt_d = CW'(NFLUSH);
    else if (flushing) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a flush run ends right after its final step
  assert_flush_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    final_step |=> !flushing);

endmodule

// File: rtl/tcc_puncture.sv
module tcc_puncture
  import tcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       restart,
  input  rate_e      rate_in,
  input  logic [1:0] code,
  input  logic       last_step,
  output logic       sym_valid_o,
  output sym_t       sym_o
);
  rate_e rate_q, rate_d, eff_rate;
  logic  phase_q, phase_d, eff_phase, drop;
  logic  valid_q;
  sym_t  sym_q, sym_d;

  always_comb begin
    eff_rate  = restart ? rate_in : rate_q;
    eff_phase = restart ? 1'b0 : phase_q;
    drop      = (eff_rate == RATE_2_3) && eff_phase;
    sym_d.bits = drop ? {code[1], 1'b0} : code;
    sym_d.pair = !drop;
    sym_d.eof  = last_step;
    phase_d   = step ? ~eff_phase : phase_q;
    rate_d    = (step && restart) ? rate_in : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= RATE_1_2;
      phase_q <= 1'b0;
      valid_q <= 1'b0;
      sym_q   <= '0;
    end else begin
      rate_q  <= rate_d;
      phase_q <= phase_d;
      valid_q <= step;
      if (step) sym_q <= sym_d;
    end
  end

  assign sym_valid_o = valid_q;
  assign sym_o       = sym_q;

  // R7: single-bit symbols only in rate 2/3
  assert_drop_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !sym_q.pair) |-> rate_q == RATE_2_3);
  // R7: punctured position carries zero
  assert_drop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !sym_q.pair) |-> sym_q.bits[0] == 1'b0);
  // R8: latched rate moves only on a start-of-frame step
  assert_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && restart) |=> rate_q == $past(rate_q));

endmodule

// File: rtl/tcc_encoder.sv
module tcc_encoder
  import tcc_pkg::*;
#(
  parameter int           K  = 3,
  parameter logic [K-1:0] GA = 3'b111,
  parameter logic [K-1:0] GB = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_sof,
  input  logic       in_last,
  input  logic       rate_sel,
  output logic       in_ready,
  output logic       sym_valid,
  output logic [1:0] sym_bits,
  output logic       sym_pair,
  output logic       sym_eof
);
  localparam int NFLUSH = K - 1;

  logic [1:0]   rst_sync_q;
  logic         rst_q;
  logic         accept, step, din, restart, flushing, final_step;
  logic [1:0]   code;
  logic [K-2:0] core_state;
  logic         pv;
  sym_t         ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  always_comb begin
    in_ready = !flushing;
    accept   = in_valid && in_ready;
    step     = accept || flushing;
    din      = accept && in_bit;
    restart  = accept && in_sof;
  end

  tcc_shift_core #(.K(K), .GA(GA), .GB(GB)) u_core (
    .clk   (clk),
    .rst_n (rst_q),
    .step  (step),
    .clear (restart),
    .din   (din),
    .code  (code),
    .state (core_state)
  );

  tcc_flush_ctrl #(.NFLUSH(NFLUSH)) u_flush (
    .clk        (clk),
    .rst_n      (rst_q),
    .start      (accept && in_last),
    .flushing   (flushing),
    .final_step (final_step)
  );

  tcc_puncture u_punct (
    .clk         (clk),
    .rst_n       (rst_q),
    .step        (step),
    .restart     (restart),
    .rate_in     (rate_e'(rate_sel)),
    .code        (code),
    .last_step   (flushing && final_step),
    .sym_valid_o (pv),
    .sym_o       (ps)
  );

  assign sym_valid = pv;
  assign sym_bits  = ps.bits;
  assign sym_pair  = ps.pair;
  assign sym_eof   = pv && ps.eof;

  // R5: trellis is back at zero when the end-of-frame symbol leaves
  assert_term_zero_R5: assert property (@(posedge clk) disable iff (!rst_q)
    sym_eof |-> core_state == '0);

endmodule

// File: tb/tcc_encoder_test.sv
module tcc_encoder_test;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_bit, in_sof, in_last, rate_sel;
  logic in_ready, sym_valid, sym_pair, sym_eof;
  logic [1:0] sym_bits;

  int checks = 0;
  int errors = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  logic m_d1, m_d2, m_phase, m_rate;
  logic [3:0] e;
  string t;

  always #5 clk = ~clk;

  tcc_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_sof(in_sof), .in_last(in_last), .rate_sel(rate_sel),
    .in_ready(in_ready), .sym_valid(sym_valid), .sym_bits(sym_bits),
    .sym_pair(sym_pair), .sym_eof(sym_eof)
  );

  task automatic check(input logic ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // reference encoder: pushes one expected symbol per step
  task automatic model_step(input logic b, input logic restart, input logic rate_now,
                            input logic last, input string tag);
    logic g0, g1;
    if (restart) begin
      m_d1 = 1'b0; m_d2 = 1'b0; m_phase = 1'b0; m_rate = rate_now;
    end
    g0 = b ^ m_d1 ^ m_d2;
    g1 = b ^ m_d2;
    if (m_rate && m_phase) exp_q.push_back({g0, 1'b0, 1'b0, last});
    else                   exp_q.push_back({g0, g1, 1'b1, last});
    tag_q.push_back(tag);
    m_d2 = m_d1; m_d1 = b; m_phase = ~m_phase;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && sym_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected symbol", {sym_bits, sym_pair, sym_eof}, 4'b0000);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({sym_bits, sym_pair, sym_eof} === e, t, {sym_bits, sym_pair, sym_eof}, e);
      end
    end
  end

  task automatic send_frame(input logic [31:0] bits, input int n, input logic rate,
                            input int gap, input int flip_at, input logic do_last,
                            input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_bit   = bits[i];
      in_sof   = (i == 0);
      in_last  = do_last && (i == n - 1);
      rate_sel = (flip_at >= 0 && i >= flip_at) ? ~rate : rate;
      model_step(bits[i], i == 0, rate_sel, 1'b0, tag);
      if (in_last) begin
        model_step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        model_step(1'b0, 1'b0, 1'b0, 1'b1, "R5");
      end
      if (gap > 0 && i != n - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        if (gap >= 2) begin
          @(negedge clk);
          check(sym_valid == 1'b0, "R9 idle cycle", {3'b0, sym_valid}, 4'b0000);
          repeat (gap - 2) @(negedge clk);
        end
      end
    end
    if (do_last) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
      if (flip_at >= 0) rate_sel = ~rate_sel; // R8: toggle during flush too
      check(in_ready == 1'b0, "R4 ready low flush1", {3'b0, in_ready}, 4'b0000);
      @(negedge clk);
      check(in_ready == 1'b0, "R4 ready low flush2", {3'b0, in_ready}, 4'b0000);
      @(negedge clk);
      check(in_ready == 1'b1, "R4 ready back", {3'b0, in_ready}, 4'b0001);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; in_sof = 1'b0;
    in_last = 1'b0; rate_sel = 1'b0;
    m_d1 = 1'b0; m_d2 = 1'b0; m_phase = 1'b0; m_rate = 1'b0;
    repeat (3) @(negedge clk);
    check(sym_valid == 1'b0 && in_ready == 1'b1, "R1 in reset",
          {2'b0, sym_valid, in_ready}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sym_valid == 1'b0 && in_ready == 1'b1, "R1 after release",
          {2'b0, sym_valid, in_ready}, 4'b0001);

    // R2/R6: 15-bit frame at rate 1/2, back to back (first bits 0 then 1 from state 00)
    send_frame(32'h0000_5B2A, 15, 1'b0, 0, -1, 1'b1, "R6");
    // R2: single 1 from zero state gives 11
    send_frame(32'h0000_0001, 3, 1'b0, 0, -1, 1'b1, "R2");
    // R7/R9: 15-bit frame at rate 2/3 with idle gaps
    send_frame(32'h0000_6E93, 15, 1'b1, 3, -1, 1'b1, "R7");
    // R8: rate changed in mid-frame
    send_frame(32'h0000_0B7D, 12, 1'b1, 0, 4, 1'b1, "R8");
    send_frame(32'h0000_0365, 10, 1'b0, 1, 3, 1'b1, "R8");
    // R3: unfinished frame cut off by a new start-of-frame
    send_frame(32'h0000_0037, 6, 1'b0, 0, -1, 1'b0, "R3");
    send_frame(32'h0000_0019, 5, 1'b1, 0, -1, 1'b1, "R3");
    // R4: one-bit frame
    send_frame(32'h0000_0001, 1, 1'b1, 0, -1, 1'b1, "R4");

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 all symbols delivered", 4'(exp_q.size()), 4'b0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule